// File: doc/BRIEF.md
# AHB-Lite Burst Address Generator

This unit sits on the manager side of an AHB-Lite bus and produces the address phase of every beat of a burst. A client presents a start address, a burst code, a transfer size and a direction. The unit checks the request, and if the request is legal it drives the bus address and control for each beat until the burst ends. Incrementing bursts advance by the transfer size on each beat. Wrapping bursts stay inside an aligned window whose size is the beat count times the bytes per beat. Whenever the bus signals a wait state, the current address phase is held unchanged.

Requests are offered with a valid/ready pair. A request is taken when the unit is idle. It is also taken in the same cycle that the final beat of the current burst completes, so consecutive bursts run with no idle slot between them. A request with an illegal size, a misaligned start address or the undefined-length code is refused with a one-cycle error indication, and no bus activity follows it.

Top module: `ahb_burst_addr_gen`

## Requirements
- R1: After reset, `htrans` is IDLE (2'b00), `busy` is low and `req_ready` is high.
- R2: When a legal request is taken (`req_valid` and `req_ready` high, `req_error` low), the next cycle shows `htrans` NONSEQ (2'b10), `haddr` equal to the start address, and `hburst`, `hsize` and `hwrite` equal to the requested values.
- R3: Every beat after the first is driven with `htrans` SEQ (2'b11). `hburst`, `hsize` and `hwrite` keep the same values for the whole burst.
- R4: Burst code 3'b000 is a single beat. Codes 3'b011, 3'b101 and 3'b111 are incrementing bursts of 4, 8 and 16 beats. Each beat's address is the previous one plus 2^`hsize` bytes.
- R5: Codes 3'b010, 3'b100 and 3'b110 are wrapping bursts of 4, 8 and 16 beats. Addresses advance by 2^`hsize` and wrap within an aligned window of beats × 2^`hsize` bytes, and the address bits above that window are unchanged. Example: an 8-beat wrap of 4-byte beats starting at 0x1834 gives 0x1834, 0x1838, 0x183C, 0x1820, 0x1824, 0x1828, 0x182C, 0x1830.
- R6: While `hready` is low during an active burst, `haddr`, `htrans`, `hburst`, `hsize` and `hwrite` hold their values into the next cycle.
- R7: A request whose start address is not a multiple of 2^`req_size` is refused: `req_error` is high in that cycle and `htrans` stays IDLE. Example: 0x1832 with size 3'b010.
- R8: A request with `req_size` greater than log2(DATA_W/8) is refused in the same way. With DATA_W of 32 this means sizes 3'b011 and above; with DATA_W of 64 it means 3'b100 and above.
- R9: Burst code 3'b001 (undefined length) is refused in the same way.
- R10: `busy` is high from the cycle after a request is taken until the last beat's address phase completes with `hready` high. `req_ready` is high when the unit is idle, or when the last beat is completing in this cycle. This lets a new burst start with no IDLE cycle in between.
- R11: After the last beat completes and no request is taken, `htrans` returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Burst request offered |
| req_addr | input | ADDR_W | Start address of the requested burst |
| req_burst | input | 3 | Requested burst code |
| req_size | input | 3 | Requested transfer size, log2 of bytes per beat |
| req_write | input | 1 | Requested direction, 1 = write |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_error | output | 1 | Offered request is refused this cycle |
| busy | output | 1 | A burst is in progress |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Bus transfer type |
| hburst | output | 3 | Bus burst code |
| hsize | output | 3 | Bus transfer size |
| hwrite | output | 1 | Bus direction |
| hready | input | 1 | Bus ready; low extends the current address phase |

## Verification
The bench builds the unit with a 32-bit data bus and 32-bit addresses. With these values, size 3'b011 is one step above the legal maximum, so the oversize refusal path can be tested next to the largest legal size. The 32-bit address width lets random start addresses reach the top of the address space, which tests incrementing carries and wrap windows high in memory. Random wait states on `hready` are applied during every burst shape, including on the final beat where a chained request is offered.

// File: rtl/ahb_ag_pkg.sv
package ahb_ag_pkg;

    typedef enum logic [1:0] {
        HT_IDLE   = 2'b00,
        HT_BUSY   = 2'b01,
        HT_NONSEQ = 2'b10,
        HT_SEQ    = 2'b11
    } htrans_e;

    // burst code with no defined length; not supported by this unit
    localparam logic [2:0] BURST_UNDEF_LEN = 3'b001;
    localparam logic [2:0] BURST_ONE       = 3'b000;

endpackage

// File: rtl/ahb_ag_req_check.sv
module ahb_ag_req_check #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        burst,
    input  logic [2:0]        size,
    output logic              legal,
    output logic [4:0]        beats
);
    import ahb_ag_pkg::*;

    localparam int MAX_SIZE = $clog2(DATA_W / 8);

    logic [ADDR_W-1:0] low_mask;
    logic              misaligned;
    logic              oversize;

    always_comb begin
        low_mask   = (ADDR_W'(1) << size) - ADDR_W'(1);
        misaligned = (addr & low_mask) != '0;
        oversize   = size > 3'(MAX_SIZE);
        legal      = !misaligned && !oversize && (burst != BURST_UNDEF_LEN);
        beats      = (burst == BURST_ONE) ? 5'd1 : (5'd2 << burst[2:1]);
    end

endmodule

// File: rtl/ahb_ag_addr_step.sv
module ahb_ag_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        burst,
    input  logic [2:0]        size,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] window;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] incr;
    logic              wrapping;

    always_comb begin
        step      = ADDR_W'(1) << size;
        // beats per burst are 4/8/16 for codes 01x/10x/11x
        window    = ADDR_W'(5'd2 << burst[2:1]) << size;
        win_mask  = window - ADDR_W'(1);
        incr      = addr + step;
        wrapping  = (burst != 3'b000) && !burst[0];
        next_addr = wrapping ? ((addr & ~win_mask) | (incr & win_mask)) : incr;
    end

endmodule

// File: rtl/ahb_burst_addr_gen.sv
module ahb_burst_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_burst,
    input  logic [2:0]        req_size,
    input  logic              req_write,
    output logic              req_ready,
    output logic              req_error,
    output logic              busy,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic [2:0]        hburst,
    output logic [2:0]        hsize,
    output logic              hwrite,
    input  logic              hready
);
    import ahb_ag_pkg::*;

    typedef struct packed {
        logic              active;
        logic              first;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        burst;
        logic [2:0]        size;
        logic              write;
        logic [4:0]        left;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic              req_legal;
    logic [4:0]        req_beats;
    logic [ADDR_W-1:0] step_addr;
    logic              last_beat;
    logic              take;

    ahb_ag_req_check #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) check_i (
        .addr  (req_addr),
        .burst (req_burst),
        .size  (req_size),
        .legal (req_legal),
        .beats (req_beats)
    );

    ahb_ag_addr_step #(
        .ADDR_W (ADDR_W)
    ) step_i (
        .addr      (st_q.addr),
        .burst     (st_q.burst),
        .size      (st_q.size),
        .next_addr (step_addr)
    );

    always_comb begin
        last_beat = st_q.active && (st_q.left == 5'd1);
        req_ready = !st_q.active || (hready && last_beat);
        req_error = req_valid && req_ready && !req_legal;
        take      = req_valid && req_ready && req_legal;

        st_d = st_q;
        if (st_q.active && hready) begin
            if (last_beat) begin
                st_d.active = 1'b0;
            end else begin
                st_d.addr  = step_addr;
                st_d.left  = st_q.left - 5'd1;
                st_d.first = 1'b0;
            end
        end
        if (take) begin
            st_d.active = 1'b1;
            st_d.first  = 1'b1;
            st_d.addr   = req_addr;
            st_d.burst  = req_burst;
            st_d.size   = req_size;
            st_d.write  = req_write;
            st_d.left   = req_beats;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        busy   = st_q.active;
        haddr  = st_q.addr;
        hburst = st_q.burst;
        hsize  = st_q.size;
        hwrite = st_q.write;
        if (!st_q.active) begin
            htrans = HT_IDLE;
        end else if (st_q.first) begin
            htrans = HT_NONSEQ;
        end else begin
            htrans = HT_SEQ;
        end
    end

endmodule

// File: rtl/ahb_burst_addr_gen_chk.sv
module ahb_burst_addr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_error,
    input logic              busy,
    input logic [ADDR_W-1:0] haddr,
    input logic [1:0]        htrans,
    input logic [2:0]        hburst,
    input logic [2:0]        hsize,
    input logic              hwrite,
    input logic              hready
);
    localparam int MAX_SIZE = $clog2(DATA_W / 8);

    AST_TAKE_GIVES_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_error) |=> (htrans == 2'b10)); // R2

    AST_SEQ_CTRL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11) |-> ($stable(hburst) && $stable(hsize) && $stable(hwrite))); // R3

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00 && !hready) |=> ($stable(haddr) && $stable(htrans) && $stable(hburst)
                                          && $stable(hsize) && $stable(hwrite))); // R6

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> ((haddr & ((ADDR_W'(1) << hsize) - ADDR_W'(1))) == '0)); // R7

    AST_REFUSE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (req_error && !busy) |=> (htrans == 2'b00)); // R7

    AST_SIZE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> (hsize <= 3'(MAX_SIZE))); // R8

    AST_NO_UNDEF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> (hburst != 3'b001)); // R9

    AST_BUSY_DURING_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> busy); // R10

endmodule

bind ahb_burst_addr_gen ahb_burst_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_error (req_error),
    .busy      (busy),
    .haddr     (haddr),
    .htrans    (htrans),
    .hburst    (hburst),
    .hsize     (hsize),
    .hwrite    (hwrite),
    .hready    (hready)
);

// File: tb/ahb_burst_addr_gen_tb.sv
module ahb_burst_addr_gen_tb_top;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int MAXSZ  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0]        req_burst = '0;
    logic [2:0]        req_size = '0;
    logic              req_write = 1'b0;
    logic              req_ready;
    logic              req_error;
    logic              busy;
    logic [ADDR_W-1:0] haddr;
    logic [1:0]        htrans;
    logic [2:0]        hburst;
    logic [2:0]        hsize;
    logic              hwrite;
    logic              hready = 1'b1;

    always #4 clk = ~clk;

    ahb_burst_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_burst(req_burst), .req_size(req_size), .req_write(req_write),
        .req_ready(req_ready), .req_error(req_error), .busy(busy), .haddr(haddr),
        .htrans(htrans), .hburst(hburst), .hsize(hsize), .hwrite(hwrite), .hready(hready)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // reference model state
    int unsigned q_addr[$];
    int          m_burst, m_size, m_write;
    bit          m_first, m_wrap, prev_stall;
    bit          got_take, got_err;

    task automatic chk(string tag, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit legal_req(int unsigned a, int b, int s);
        if (b == 1) return 0;
        if (s > MAXSZ) return 0;
        return (a % (32'd1 << s)) == 0;
    endfunction

    task automatic cycle(bit v, int unsigned a, int b, int s, bit w, bit rdy);
        bit act, exp_rdy, lg;
        @(negedge clk);
        req_valid = v; req_addr = a; req_burst = 3'(b); req_size = 3'(s);
        req_write = w; hready = rdy;
        #1;
        act     = q_addr.size() > 0;
        exp_rdy = !act || (rdy && q_addr.size() == 1);
        lg      = legal_req(a, b, s);
        chk("R10", "busy", busy, act);
        chk("R10", "req_ready", req_ready, exp_rdy);
        chk(lg ? "R7" : (s > MAXSZ ? "R8" : (b == 1 ? "R9" : "R7")), "req_error",
            req_error, v && exp_rdy && !lg);
        if (!act) begin
            chk("R11", "htrans idle", htrans, 0);
        end else begin
            chk(m_first ? "R2" : "R3", "htrans", htrans, m_first ? 2 : 3);
            chk(prev_stall ? "R6" : (m_first ? "R2" : (m_wrap ? "R5" : "R4")), "haddr",
                haddr, q_addr[0]);
            chk(m_first ? "R2" : "R3", "hburst", hburst, m_burst);
            chk(m_first ? "R2" : "R3", "hsize", hsize, m_size);
            chk(m_first ? "R2" : "R3", "hwrite", hwrite, m_write);
        end
        prev_stall = act && !rdy;
        got_take = v && exp_rdy && lg;
        got_err  = v && exp_rdy && !lg;
        if (act && rdy) begin
            void'(q_addr.pop_front());
            m_first = 0;
        end
        if (got_take) begin
            int beats, step, total;
            int unsigned base;
            beats = (b == 0) ? 1 : (b / 2 == 1 ? 4 : (b / 2 == 2 ? 8 : 16));
            step  = 1 << s;
            total = beats * step;
            m_wrap = (b != 0) && (b % 2 == 0);
            base  = a - (a % total);
            q_addr.delete();
            for (int i = 0; i < beats; i++) begin
                if (m_wrap) q_addr.push_back(base + ((a - base) + i * step) % total);
                else        q_addr.push_back(a + i * step);
            end
            m_burst = b; m_size = s; m_write = w; m_first = 1;
        end
    endtask

    // offer a request until it is taken or refused; pct = hready high chance
    task automatic issue(int unsigned a, int b, int s, bit w, int pct);
        do cycle(1, a, b, s, w, ($urandom % 100) < pct);
        while (!got_take && !got_err);
    endtask

    task automatic drain(int pct);
        while (q_addr.size() > 0) cycle(0, 0, 0, 0, 0, ($urandom % 100) < pct);
        cycle(0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #(8 * 150000);
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        end
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "htrans", htrans, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "req_ready", req_ready, 1);
        rst_n = 1'b1;
        cycle(0, 0, 0, 0, 0, 1);

        // R5: 8-beat wrap of 4-byte beats from 0x1834, no stalls then with stalls
        issue(32'h1834, 4, 2, 1, 100); drain(100);
        issue(32'h1834, 4, 2, 0, 100); drain(50);
        // R4: 4-beat byte increment, single beat, 16-beat halfword increment
        issue(32'h20, 3, 0, 1, 100); drain(100);
        issue(32'h40, 0, 2, 0, 100); drain(100);
        issue(32'h3F0, 7, 1, 1, 100); drain(70);
        // R5: 4-beat and 16-beat wraps
        issue(32'h106, 2, 1, 0, 100); drain(60);
        issue(32'hFFFF_FFE8, 6, 2, 1, 100); drain(100);
        // R7, R8, R9: refusals
        issue(32'h1832, 4, 2, 0, 100); cycle(0, 0, 0, 0, 0, 1);
        issue(32'h1000, 3, 3, 0, 100); cycle(0, 0, 0, 0, 0, 1);
        issue(32'h1000, 1, 0, 0, 100); cycle(0, 0, 0, 0, 0, 1);
        // R10: chained bursts with no idle between
        issue(32'h200, 3, 2, 1, 100);
        issue(32'h300, 2, 2, 0, 60);
        issue(32'h400, 5, 0, 1, 60);
        drain(60);

        // mixed random traffic
        for (int k = 0; k < 400; k++) begin
            int unsigned a;
            int b, s;
            a = $urandom;
            b = $urandom % 8;
            s = $urandom % 4;
            if (($urandom % 5) != 0) a = a & ~((32'd1 << s) - 1);
            issue(a, b, s, 1'($urandom), 70);
            if (($urandom % 3) == 0) drain(70);
        end
        drain(70);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        end
        $finish;
    end

endmodule